// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the byte-wide register front end of a three-channel programmable interval timer. A host reaches it through a two-bit address. Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 is a control port that can only be written. Control words program each channel's byte access pattern, counting mode and BCD flag. They also issue count-latch commands and multi-channel read-back commands. The counting engines sit outside this block. Each engine receives a one-cycle load strobe with a 16-bit initial count, plus its counting mode and BCD flag. Each engine returns its live count and its output level.

Each channel keeps its own write and read byte sequencing. A latched count is a one-shot snapshot that later latch commands cannot overwrite until the host has read it out. A latched status byte is always returned ahead of a latched count. All outputs are registered in the single bus clock domain. Read data appears in the cycle after the read strobe.

Top module: `itimer_regif`

## Requirements
- R1: A read of address 3 returns 0x00 in `bus_rdata` and does not disturb any pending latch or read sequence.
- R2: A control word with bits 7:6 not equal to 3 targets the channel given by bits 7:6. If bits 5:4 are nonzero, they set that channel's access code (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 become its `ch_mode` field and bit 0 its `ch_bcd` bit, all visible from the cycle after the write. `ch_mode` and `ch_bcd` change only on control-port writes.
- R3: Programming a nonzero access code restarts that channel's write and read byte sequencing at the low byte, discarding a half-written pair.
- R4: In low-only access a data write loads {0x00, byte}. In high-only access it loads {byte, 0x00}. `ch_load` pulses for exactly the cycle after the write, and `ch_init_cnt` holds the value until the next load.
- R5: In two-byte access the first data write loads nothing. The second loads {second, first}, after which the next write is again a low byte.
- R6: Only data-port writes produce `ch_load`, on the addressed channel only. Control writes never do.
- R7: A counter-latch command (bits 5:4 = 0) captures `ch_cur_cnt` as sampled at the command's clock edge. It is ignored while a latched count of that channel is still unread.
- R8: A latched count is read as the low byte (low-only), the high byte (high-only), or the low then the high byte (two-byte), after which the latch is released.
- R9: With nothing latched, a data read returns the live count: the low byte in low-only access, the high byte in high-only access, and alternately low then high, starting low, in two-byte access. Reads of latched values do not advance this alternation.
- R10: A control word with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 requests a count latch (skipped if one is unread), and bit 4 = 0 requests a status latch (skipped if a status is unread).
- R11: The status byte is {output level at the command edge, 0, access code, counting mode, BCD flag}. A pending status is returned by the next data read and cleared, ahead of any latched count.
- R12: After reset, every channel is in two-byte access, mode 0, BCD 0, with no latch pending. `bus_rdata`, `ch_load` and `ch_init_cnt` are zero.
- R13: `bus_rdata` changes only in the cycle after a read strobe. A read strobe raised together with a write strobe is ignored, and the write proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port select: 0-2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| ch_load | output | 3 | Per-channel load strobe |
| ch_init_cnt | output | 48 | Per-channel initial count, 16 bits each, channel 0 lowest |
| ch_mode | output | 9 | Per-channel counting mode, 3 bits each |
| ch_bcd | output | 3 | Per-channel BCD flag |
| ch_cur_cnt | input | 48 | Per-channel live count, 16 bits each |
| ch_out | input | 3 | Per-channel output level |

## Verification
A corrupted sequencing bit or latch state in this block shows up at the ports within one transaction. A wrong write-pairing flag gives a load one write early or late, or swaps the bytes. A wrong read flag returns the other half of the count on the very next read. A latch that is wrongly released or recaptured returns a live value where a frozen snapshot was expected. The bench therefore changes the live count between each latch command and its reads. It also sweeps every channel, access code, mode and BCD value through a status read-back, so that a misplaced status field appears on the first read after the command.

// File: rtl/itimer_regif_pkg.sv
`timescale 1ns/1ps
package itimer_regif_pkg;

   // Byte access code; the zero value doubles as "no latch pending"
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_WORD = 2'd3
   } acc_e;

   localparam int          MODE_W   = 3;
   localparam logic [1:0]  CTL_PORT = 2'd3;
   localparam logic [1:0]  RB_CODE  = 2'd3;

endpackage

// File: rtl/itimer_ctl_decode.sv
`timescale 1ns/1ps
module itimer_ctl_decode
   import itimer_regif_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [NUM_CH-1:0] data_wr,
   output logic [NUM_CH-1:0] prog,
   output logic [NUM_CH-1:0] cnt_latch,
   output logic [NUM_CH-1:0] sts_latch
);

   logic       ctl_wr;
   logic       is_rb;
   logic [1:0] sel_f;
   logic [1:0] acc_f;

   assign ctl_wr = bus_wr && (bus_addr == CTL_PORT);
   assign sel_f  = bus_wdata[7:6];
   assign acc_f  = bus_wdata[5:4];
   assign is_rb  = (sel_f == RB_CODE);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [1:0] IDX = 2'(i);
      logic hit;
      logic rb_hit;
      assign hit    = ctl_wr && !is_rb && (sel_f == IDX);
      assign rb_hit = ctl_wr && is_rb && bus_wdata[i+1];

      assign data_wr[i]   = bus_wr && (bus_addr == IDX);
      assign prog[i]      = hit && (acc_f != ACC_NONE);
      assign cnt_latch[i] = (hit && (acc_f == ACC_NONE)) || (rb_hit && !bus_wdata[5]);
      assign sts_latch[i] = rb_hit && !bus_wdata[4];
   end

endmodule

// File: rtl/itimer_chan_regs.sv
`timescale 1ns/1ps
module itimer_chan_regs
   import itimer_regif_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic              data_wr,
   input  logic              prog,
   input  logic              cnt_latch,
   input  logic              sts_latch,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  cur_cnt,
   input  logic              out_lvl,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              load,
   output logic [CNT_W-1:0]  init_cnt,
   output logic [MODE_W-1:0] mode,
   output logic              bcd
);

   localparam int LO_W = CNT_W - BYTE_W;

   acc_e              rw_q;
   logic [MODE_W-1:0] mode_q;
   logic              bcd_q;
   logic              rd_hi_q;
   logic              wr_hi_q;
   logic [BYTE_W-1:0] wr_lo_q;
   acc_e              cl_q;
   logic [CNT_W-1:0]  lat_q;
   logic              st_pend_q;
   logic [BYTE_W-1:0] st_q;
   logic              load_q;
   logic [CNT_W-1:0]  init_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rw_q      <= ACC_WORD;
         mode_q    <= '0;
         bcd_q     <= 1'b0;
         rd_hi_q   <= 1'b0;
         wr_hi_q   <= 1'b0;
         wr_lo_q   <= '0;
         cl_q      <= ACC_NONE;
         lat_q     <= '0;
         st_pend_q <= 1'b0;
         st_q      <= '0;
         load_q    <= 1'b0;
         init_q    <= '0;
      end else begin
         load_q <= 1'b0;

         if (prog) begin
            rw_q    <= acc_e'(wbyte[5:4]);
            mode_q  <= wbyte[3:1];
            bcd_q   <= wbyte[0];
            rd_hi_q <= 1'b0;
            wr_hi_q <= 1'b0;
         end

         if (cnt_latch && (cl_q == ACC_NONE)) begin
            lat_q <= cur_cnt;
            cl_q  <= rw_q;
         end

         if (sts_latch && !st_pend_q) begin
            st_q      <= {out_lvl, 1'b0, rw_q, mode_q, bcd_q};
            st_pend_q <= 1'b1;
         end

         if (data_wr) begin
            unique case (rw_q)
               ACC_LO: begin
                  init_q <= {{LO_W{1'b0}}, wbyte};
                  load_q <= 1'b1;
               end
               ACC_HI: begin
                  init_q <= {wbyte, {LO_W{1'b0}}};
                  load_q <= 1'b1;
               end
               default: begin
                  if (!wr_hi_q) begin
                     wr_lo_q <= wbyte;
                     wr_hi_q <= 1'b1;
                  end else begin
                     init_q  <= {wbyte, wr_lo_q};
                     load_q  <= 1'b1;
                     wr_hi_q <= 1'b0;
                  end
               end
            endcase
         end

         if (rd_en) begin
            if (st_pend_q) begin
               st_pend_q <= 1'b0;
            end else if (cl_q != ACC_NONE) begin
               cl_q <= (cl_q == ACC_WORD) ? ACC_HI : ACC_NONE;
            end else if (rw_q == ACC_WORD) begin
               rd_hi_q <= !rd_hi_q;
            end
         end
      end
   end

   always_comb begin
      if (st_pend_q) begin
         rd_byte = st_q;
      end else if (cl_q == ACC_HI) begin
         rd_byte = lat_q[CNT_W-1 -: BYTE_W];
      end else if (cl_q != ACC_NONE) begin
         rd_byte = lat_q[BYTE_W-1:0];
      end else if ((rw_q == ACC_HI) || ((rw_q == ACC_WORD) && rd_hi_q)) begin
         rd_byte = cur_cnt[CNT_W-1 -: BYTE_W];
      end else begin
         rd_byte = cur_cnt[BYTE_W-1:0];
      end
   end

   assign load     = load_q;
   assign init_cnt = init_q;
   assign mode     = mode_q;
   assign bcd      = bcd_q;

endmodule

// File: rtl/itimer_rd_mux.sv
`timescale 1ns/1ps
module itimer_rd_mux #(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic [1:0]               addr,
   input  logic [NUM_CH*BYTE_W-1:0] ch_bytes,
   output logic [BYTE_W-1:0]        sel_byte
);

   always_comb begin
      sel_byte = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == 2'(i)) sel_byte = ch_bytes[i*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/itimer_regif.sv
`timescale 1ns/1ps
module itimer_regif
   import itimer_regif_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                bus_addr,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [BYTE_W-1:0]         bus_wdata,
   output logic [BYTE_W-1:0]         bus_rdata,
   output logic [NUM_CH-1:0]         ch_load,
   output logic [NUM_CH*CNT_W-1:0]   ch_init_cnt,
   output logic [NUM_CH*MODE_W-1:0]  ch_mode,
   output logic [NUM_CH-1:0]         ch_bcd,
   input  logic [NUM_CH*CNT_W-1:0]   ch_cur_cnt,
   input  logic [NUM_CH-1:0]         ch_out
);

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("itimer_regif: NUM_CH must be 1 to 3");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("itimer_regif: control word layout needs BYTE_W of 8");
   end
   if (CNT_W != 2 * BYTE_W) begin : g_bad_cnt
      $error("itimer_regif: CNT_W must be two bytes");
   end

   logic [NUM_CH-1:0]        data_wr;
   logic [NUM_CH-1:0]        prog;
   logic [NUM_CH-1:0]        cnt_latch;
   logic [NUM_CH-1:0]        sts_latch;
   logic [NUM_CH-1:0]        rd_en;
   logic [NUM_CH*BYTE_W-1:0] ch_bytes;
   logic [BYTE_W-1:0]        sel_byte;
   logic                     rd_fire;
   logic [BYTE_W-1:0]        rdata_q;

   assign rd_fire = bus_rd && !bus_wr;

   itimer_ctl_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .data_wr   (data_wr),
      .prog      (prog),
      .cnt_latch (cnt_latch),
      .sts_latch (sts_latch)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      assign rd_en[i] = rd_fire && (bus_addr == 2'(i));

      itimer_chan_regs #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wbyte     (bus_wdata),
         .data_wr   (data_wr[i]),
         .prog      (prog[i]),
         .cnt_latch (cnt_latch[i]),
         .sts_latch (sts_latch[i]),
         .rd_en     (rd_en[i]),
         .cur_cnt   (ch_cur_cnt[i*CNT_W +: CNT_W]),
         .out_lvl   (ch_out[i]),
         .rd_byte   (ch_bytes[i*BYTE_W +: BYTE_W]),
         .load      (ch_load[i]),
         .init_cnt  (ch_init_cnt[i*CNT_W +: CNT_W]),
         .mode      (ch_mode[i*MODE_W +: MODE_W]),
         .bcd       (ch_bcd[i])
      );
   end

   itimer_rd_mux #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_mux (
      .addr     (bus_addr),
      .ch_bytes (ch_bytes),
      .sel_byte (sel_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_fire) rdata_q <= sel_byte;
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/itimer_regif_chk.sv
`timescale 1ns/1ps
module itimer_regif_chk #(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              bus_addr,
   input logic                    bus_wr,
   input logic                    bus_rd,
   input logic [BYTE_W-1:0]       bus_rdata,
   input logic [NUM_CH-1:0]       ch_load,
   input logic [NUM_CH*CNT_W-1:0] ch_init_cnt,
   input logic [NUM_CH*3-1:0]     ch_mode,
   input logic [NUM_CH-1:0]       ch_bcd
);

   AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == 2'd3) |=> (bus_rdata == '0)); // R1

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && !bus_wr) |=> $stable(bus_rdata)); // R13

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == 2'd3) |=> ($stable(ch_mode) && $stable(ch_bcd))); // R2

   AST_NO_LOAD_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3) |=> (ch_load == '0)); // R6

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         ch_load[i] |-> ($past(bus_wr) && ($past(bus_addr) == 2'(i)))); // R6

      AST_INIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_load[i] |-> $stable(ch_init_cnt[i*CNT_W +: CNT_W])); // R4
   end

endmodule

bind itimer_regif itimer_regif_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_rdata   (bus_rdata),
   .ch_load     (ch_load),
   .ch_init_cnt (ch_init_cnt),
   .ch_mode     (ch_mode),
   .ch_bcd      (ch_bcd)
);

// File: tb/test_itimer_regif.sv
`timescale 1ns/1ps
module test_itimer_regif;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [2:0]  ch_load;
   logic [47:0] ch_init_cnt;
   logic [8:0]  ch_mode;
   logic [2:0]  ch_bcd;
   logic [47:0] ch_cur_cnt = '0;
   logic [2:0]  ch_out = '0;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   itimer_regif i_itimer_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .ch_load     (ch_load),
      .ch_init_cnt (ch_init_cnt),
      .ch_mode     (ch_mode),
      .ch_bcd      (ch_bcd),
      .ch_cur_cnt  (ch_cur_cnt),
      .ch_out      (ch_out)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
      logic [7:0] d;
      rd(a, d);
      chk(d == exp, req, 32'(d), 32'(exp));
   endtask

   task automatic load_chk(input int ch, input logic ld, input logic [15:0] v, input string req);
      chk(ch_load[ch] == ld, req, 32'(ch_load), 32'(ld) << ch);
      if (ld) chk(ch_init_cnt[ch*16 +: 16] == v, req, 32'(ch_init_cnt[ch*16 +: 16]), 32'(v));
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      chk(bus_rdata == 8'h00, "R12", 32'(bus_rdata), 0);
      chk(ch_load == 3'b000, "R12", 32'(ch_load), 0);
      chk(ch_init_cnt == '0, "R12", ch_init_cnt[31:0], 0);
      chk(ch_mode == '0 && ch_bcd == '0, "R12", 32'({ch_mode, ch_bcd}), 0);
      wr(2'd3, 8'hE2);                       // status of channel 0
      rd_chk(2'd0, 8'h30, "R12");            // two-byte access, mode 0
      ch_cur_cnt[15:0] = 16'h1234;
      rd_chk(2'd0, 8'h34, "R12");
      rd_chk(2'd0, 8'h12, "R12");

      // R2 R10 R11 R9: sweep of status read-back over every setting
      for (int ch = 0; ch < 3; ch++) begin
         for (int acc = 1; acc < 4; acc++) begin
            for (int md = 0; md < 8; md++) begin
               for (int b = 0; b < 2; b++) begin
                  logic [7:0]  ctl;
                  logic [15:0] cur;
                  logic        o;
                  ctl = {2'(ch), 2'(acc), 3'(md), 1'(b)};
                  wr(2'd3, ctl);
                  chk(ch_load == 3'b000, "R6", 32'(ch_load), 0);
                  chk(ch_mode[ch*3 +: 3] == 3'(md) && ch_bcd[ch] == 1'(b), "R2",
                      32'({ch_mode[ch*3 +: 3], ch_bcd[ch]}), 32'({3'(md), 1'(b)}));
                  o = md[0] ^ b[0];
                  ch_out[ch] = o;
                  cur = {8'(8'hA0 + ch * 16 + md), 8'(8'h10 * acc + b)};
                  ch_cur_cnt[ch*16 +: 16] = cur;
                  wr(2'd3, 8'hE0 | 8'(2 << ch));
                  rd_chk(2'(ch), {o, 1'b0, 2'(acc), 3'(md), 1'(b)}, "R11");
                  rd_chk(2'(ch), (acc == 2) ? cur[15:8] : cur[7:0], "R9");
               end
            end
         end
      end
      ch_out = '0;

      // R4 R5 R3: load byte sequencing
      for (int ch = 0; ch < 3; ch++) begin
         for (int k = 0; k < 16; k++) begin
            logic [7:0] v;
            logic [7:0] c;
            v = 8'(k * 17 + 3);
            c = {2'(ch), 6'b0};
            wr(2'd3, c | 8'h10);
            wr(2'(ch), v);
            load_chk(ch, 1'b1, {8'h00, v}, "R4");
            @(negedge clk);
            chk(ch_load == 3'b000, "R4", 32'(ch_load), 0);
            chk(ch_init_cnt[ch*16 +: 16] == {8'h00, v}, "R4",
                32'(ch_init_cnt[ch*16 +: 16]), 32'({8'h00, v}));
            wr(2'd3, c | 8'h20);
            wr(2'(ch), v);
            load_chk(ch, 1'b1, {v, 8'h00}, "R4");
            wr(2'd3, c | 8'h32);
            wr(2'(ch), v);
            load_chk(ch, 1'b0, 16'h0, "R5");
            wr(2'(ch), ~v);
            load_chk(ch, 1'b1, {~v, v}, "R5");
            wr(2'(ch), 8'h5A);
            load_chk(ch, 1'b0, 16'h0, "R5");
            wr(2'(ch), 8'hC3);
            load_chk(ch, 1'b1, 16'hC35A, "R5");
            wr(2'(ch), 8'h77);                  // half pair, then reprogram
            wr(2'd3, c | 8'h30);
            wr(2'(ch), v);
            load_chk(ch, 1'b0, 16'h0, "R3");
            wr(2'(ch), 8'h11);
            load_chk(ch, 1'b1, {8'h11, v}, "R3");
         end
      end

      // R7 R8 R9 R1: counter latch on channel 1, two-byte access
      wr(2'd3, 8'h70);
      ch_cur_cnt[31:16] = 16'hABCD;
      wr(2'd3, 8'h40);
      ch_cur_cnt[31:16] = 16'h1111;
      wr(2'd3, 8'h40);                        // ignored: latch unread
      rd_chk(2'd3, 8'h00, "R1");
      rd_chk(2'd1, 8'hCD, "R7");
      rd_chk(2'd1, 8'hAB, "R8");
      rd_chk(2'd1, 8'h11, "R9");
      ch_cur_cnt[31:16] = 16'h2233;
      rd_chk(2'd1, 8'h22, "R9");

      // R8: latch in low-only and high-only access on channel 2
      wr(2'd3, 8'h90);
      ch_cur_cnt[47:32] = 16'h5566;
      wr(2'd3, 8'h80);
      ch_cur_cnt[47:32] = 16'h7788;
      rd_chk(2'd2, 8'h66, "R8");
      rd_chk(2'd2, 8'h88, "R8");
      wr(2'd3, 8'hA0);
      ch_cur_cnt[47:32] = 16'h99AA;
      wr(2'd3, 8'h80);
      ch_cur_cnt[47:32] = 16'h0000;
      rd_chk(2'd2, 8'h99, "R8");
      rd_chk(2'd2, 8'h00, "R8");

      // R10 R11: read-back of count and status on all channels at once
      wr(2'd3, 8'h30); wr(2'd3, 8'h70); wr(2'd3, 8'hB0);
      ch_cur_cnt = 48'h0506_0304_0102;
      ch_out = 3'b101;
      wr(2'd3, 8'hCE);
      ch_cur_cnt = '1;
      ch_out = 3'b000;
      for (int ch = 0; ch < 3; ch++) begin
         rd_chk(2'(ch), (ch != 1) ? 8'hB0 : 8'h30, "R11");
         rd_chk(2'(ch), 8'(2 * ch + 2), "R10");
         rd_chk(2'(ch), 8'(2 * ch + 1), "R10");
         rd_chk(2'(ch), 8'hFF, "R10");
      end

      // R10: repeated status latch is skipped
      wr(2'd3, 8'h30);
      ch_cur_cnt[15:0] = 16'h3C4D;
      ch_out[0] = 1'b1;
      wr(2'd3, 8'hE2);
      ch_out[0] = 1'b0;
      wr(2'd3, 8'hE2);
      rd_chk(2'd0, 8'hB0, "R10");
      rd_chk(2'd0, 8'h4D, "R10");

      // R10 R7: repeated read-back count latch is skipped
      wr(2'd3, 8'h30);
      ch_cur_cnt[15:0] = 16'h4455;
      wr(2'd3, 8'hD2);
      ch_cur_cnt[15:0] = 16'h6677;
      wr(2'd3, 8'hD2);
      rd_chk(2'd0, 8'h55, "R10");
      rd_chk(2'd0, 8'h44, "R10");

      // R13: read data held; read with write is ignored
      wr(2'd3, 8'h10);
      ch_cur_cnt[15:0] = 16'h00EE;
      rd_chk(2'd0, 8'hEE, "R13");
      ch_cur_cnt[15:0] = 16'h0099;
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 8'h42; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk(bus_rdata == 8'hEE, "R13", 32'(bus_rdata), 32'hEE);
      load_chk(0, 1'b1, 16'h0042, "R13");
      repeat (3) @(negedge clk);
      chk(bus_rdata == 8'hEE, "R13", 32'(bus_rdata), 32'hEE);

      finish_up();
   end

endmodule